// File: doc/BRIEF.md
# Prioritized Interrupt and Bus-Request Arbiter

This block sits next to a processor core. At every boundary it decides which event gets service: an external bus request, a non-maskable interrupt, or one of several maskable interrupt lines. The core tells it where the boundaries are with two strobes. One marks the end of a machine cycle and the other marks the end of an instruction. Bus requests are granted at machine-cycle ends. Interrupts are only considered at instruction ends.

When a source is accepted, the arbiter registers a one-cycle acknowledge. The acknowledge carries a source code, the fetch and I/O-request strobes that match that source, and, for the non-maskable interrupt, a fixed restart address. A bus grant raises the bus acknowledge and the float output, which tells the surrounding logic to release its address, data and control drivers. Both stay high for as long as the request is held.

The non-maskable input is edge-sensitive, and an edge is held until it is serviced. The maskable inputs are active-low levels, and they are gated by an internal enable flag. Set and clear strobes drive that flag, and accepting a non-maskable interrupt also clears it.

Top module: `irq_bus_arbiter`

## Requirements
- R1: While rst_ni is low, src_o is 0 (none), and ack_stb_o, bus_ack_o, float_o, ack_m1_o, ack_iorq_o, ie_o and restart_addr_o are all 0.
- R2: When bus_req_ni is sampled low together with mcycle_end_i, bus_ack_o and float_o go high one clock later and src_o reads 1 (bus). A low request without mcycle_end_i is not granted.
- R3: bus_ack_o and float_o stay high while bus_req_ni is sampled low. They drop one clock after it is sampled high. No acknowledge strobe is issued while the bus is granted.
- R4: A falling edge on nmi_ni is latched, and a steady low level does not add further requests. The pending request is taken at the next instruction end that has no bus request and no bus grant, whatever the state of ie_o.
- R5: A taken non-maskable interrupt gives a one-cycle ack_stb_o with src_o = 2 and restart_addr_o = 16'h0066, and it clears ie_o in the same clock.
- R6: Fixed priority at an instruction end: the bus request first, then the pending non-maskable interrupt, then int_ni[0] (src_o = 3), then int_ni[1] (4), then int_ni[2] (5).
- R7: An acknowledge of int_ni[0] raises ack_m1_o and ack_iorq_o together for the strobe cycle.
- R8: Acknowledges of int_ni[1] and int_ni[2] leave both ack_m1_o and ack_iorq_o low. int_ni[1] wins over int_ni[2] when both are low.
- R9: Maskable lines are ignored while ie_o is 0. ei_i sets ie_o and di_i clears it one clock later. A non-maskable acceptance clears ie_o even when ei_i is high in the same cycle.
- R10: Interrupts are accepted only in a cycle with instr_end_i high, bus_req_ni high and no bus grant. A strobe appears one clock after that cycle, and src_o is 0 on cycles with nothing to report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_ni | input | 1 | External bus request, active low |
| nmi_ni | input | 1 | Non-maskable interrupt, falling-edge |
| int_ni | input | 3 | Maskable interrupt lines, active low, index 0 highest |
| instr_end_i | input | 1 | Instruction-end strobe |
| mcycle_end_i | input | 1 | Machine-cycle-end strobe |
| ei_i | input | 1 | Set interrupt enable |
| di_i | input | 1 | Clear interrupt enable |
| src_o | output | 3 | Selected source: 0 none, 1 bus, 2 NMI, 3..5 maskable 0..2 |
| ack_stb_o | output | 1 | One-cycle interrupt acknowledge |
| bus_ack_o | output | 1 | Bus grant |
| float_o | output | 1 | Release address, data and control drivers |
| ack_m1_o | output | 1 | Fetch strobe for the acknowledge cycle |
| ack_iorq_o | output | 1 | I/O-request strobe for the acknowledge cycle |
| restart_addr_o | output | 16 | Restart address during an NMI acknowledge |
| ie_o | output | 1 | Interrupt enable flag |

## Verification
The assertions check the following on every cycle:
- every bus grant follows a sampled request at a machine-cycle end;
- no acknowledge strobe appears during a grant;
- the fetch and I/O-request strobes only pair up for the first maskable line;
- an NMI acknowledge carries the restart address and leaves the enable clear;
- a maskable acknowledge follows an instruction end with the enable set.

The priority ordering among simultaneous sources, the latching of a single edge across a long low level, and the enable set/clear races can only be shown by the bench scenarios. The bench checks them against its reference model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned SRC_W  = 3;
  localparam int unsigned ADDR_W = 16;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_BUS  = 3'd1,
    SRC_NMI  = 3'd2,
    SRC_INT0 = 3'd3,
    SRC_INT1 = 3'd4,
    SRC_INT2 = 3'd5
  } src_e;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_ni,
  input  logic take_i,
  output logic pend_o
);
  logic nmi_q;
  logic fall;

  assign fall = nmi_q & ~nmi_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b1;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_ni;
      // a fresh edge in the taking cycle stays pending
      pend_o <= fall | (pend_o & ~take_i);
    end
  end
endmodule

// File: rtl/ie_flag.sv
module ie_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic nmi_take_i,
  output logic ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ie_o <= 1'b0;
    else if (nmi_take_i) ie_o <= 1'b0;
    else if (ei_i)       ie_o <= 1'b1;
    else if (di_i)       ie_o <= 1'b0;
  end
endmodule

// File: rtl/prio_sel.sv
module prio_sel
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_MINT = 3
) (
  input  logic              instr_end_i,
  input  logic              mcycle_end_i,
  input  logic              breq_i,
  input  logic              granted_i,
  input  logic              nmi_pend_i,
  input  logic              ie_i,
  input  logic [N_MINT-1:0] mint_i,
  output logic              bus_take_o,
  output logic              nmi_take_o,
  output logic              int_take_o,
  output logic [SRC_W-1:0]  code_o
);
  logic              window;
  logic [N_MINT-1:0] live;
  logic [N_MINT-1:0] gate;

  assign bus_take_o = ~granted_i & mcycle_end_i & breq_i;
  assign window     = instr_end_i & ~granted_i & ~breq_i;
  assign nmi_take_o = window & nmi_pend_i;

  // gate[k]: no higher-priority maskable line is live
  genvar k;
  generate
    for (k = 0; k < N_MINT; k++) begin : g_mint
      assign live[k] = mint_i[k] & ie_i;
      if (k == 0) begin : g_first
        assign gate[k] = 1'b1;
      end else begin : g_rest
        assign gate[k] = gate[k-1] & ~live[k-1];
      end
    end
  endgenerate

  always_comb begin
    code_o     = SRC_NONE;
    int_take_o = 1'b0;
    if (window && !nmi_pend_i) begin
      for (int i = 0; i < N_MINT; i++) begin
        if (live[i] && gate[i]) begin
          code_o     = SRC_W'(int'(SRC_INT0) + i);
          int_take_o = 1'b1;
        end
      end
    end else if (nmi_take_o) begin
      code_o = SRC_NMI;
    end
  end
endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned       N_MINT   = 3,
  parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0066
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_ni,
  input  logic              nmi_ni,
  input  logic [N_MINT-1:0] int_ni,
  input  logic              instr_end_i,
  input  logic              mcycle_end_i,
  input  logic              ei_i,
  input  logic              di_i,
  output logic [SRC_W-1:0]  src_o,
  output logic              ack_stb_o,
  output logic              bus_ack_o,
  output logic              float_o,
  output logic              ack_m1_o,
  output logic              ack_iorq_o,
  output logic [ADDR_W-1:0] restart_addr_o,
  output logic              ie_o
);
  logic             nmi_pend;
  logic             bus_take;
  logic             nmi_take;
  logic             int_take;
  logic [SRC_W-1:0] code;
  logic             breq;
  logic             grant_d;

  assign breq = ~bus_req_ni;

  nmi_edge_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_ni (nmi_ni),
    .take_i (nmi_take),
    .pend_o (nmi_pend)
  );

  ie_flag u_ie (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ei_i       (ei_i),
    .di_i       (di_i),
    .nmi_take_i (nmi_take),
    .ie_o       (ie_o)
  );

  prio_sel #(.N_MINT(N_MINT)) u_sel (
    .instr_end_i  (instr_end_i),
    .mcycle_end_i (mcycle_end_i),
    .breq_i       (breq),
    .granted_i    (bus_ack_o),
    .nmi_pend_i   (nmi_pend),
    .ie_i         (ie_o),
    .mint_i       (~int_ni),
    .bus_take_o   (bus_take),
    .nmi_take_o   (nmi_take),
    .int_take_o   (int_take),
    .code_o       (code)
  );

  assign grant_d = bus_ack_o ? breq : bus_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_ack_o      <= 1'b0;
      float_o        <= 1'b0;
      ack_stb_o      <= 1'b0;
      src_o          <= SRC_NONE;
      ack_m1_o       <= 1'b0;
      ack_iorq_o     <= 1'b0;
      restart_addr_o <= '0;
    end else begin
      bus_ack_o      <= grant_d;
      float_o        <= grant_d;
      ack_stb_o      <= nmi_take | int_take;
      src_o          <= grant_d ? SRC_BUS : code;
      ack_m1_o       <= int_take && code == SRC_INT0;
      ack_iorq_o     <= int_take && code == SRC_INT0;
      restart_addr_o <= nmi_take ? RST_ADDR : '0;
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_MINT = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_ni,
  input logic              instr_end_i,
  input logic              mcycle_end_i,
  input logic [SRC_W-1:0]  src_o,
  input logic              ack_stb_o,
  input logic              bus_ack_o,
  input logic              float_o,
  input logic              ack_m1_o,
  input logic              ack_iorq_o,
  input logic [ADDR_W-1:0] restart_addr_o,
  input logic              ie_o
);
  p_grant_at_mcycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_ack_o) |-> $past(!bus_req_ni && mcycle_end_i));

  p_no_stb_in_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |-> (!ack_stb_o && float_o && src_o == SRC_BUS));

  p_nmi_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_stb_o && src_o == SRC_NMI) |-> (restart_addr_o == 16'h0066 && !ie_o));

  p_int0_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_stb_o && src_o == SRC_INT0) |-> (ack_m1_o && ack_iorq_o));

  p_no_strobe_other_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_m1_o || ack_iorq_o) |-> (ack_stb_o && src_o == SRC_INT0));

  p_mask_needs_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_stb_o && src_o >= SRC_INT0) |-> $past(ie_o));

  p_stb_at_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_stb_o |-> $past(instr_end_i && bus_req_ni));
endmodule

bind irq_bus_arbiter irq_arb_chk #(.N_MINT(N_MINT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bus_req_ni     (bus_req_ni),
  .instr_end_i    (instr_end_i),
  .mcycle_end_i   (mcycle_end_i),
  .src_o          (src_o),
  .ack_stb_o      (ack_stb_o),
  .bus_ack_o      (bus_ack_o),
  .float_o        (float_o),
  .ack_m1_o       (ack_m1_o),
  .ack_iorq_o     (ack_iorq_o),
  .restart_addr_o (restart_addr_o),
  .ie_o           (ie_o)
);

// File: tb/tb_irq_bus_arbiter.sv
module tb_irq_bus_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_ni = 1'b1;
  logic        nmi_ni = 1'b1;
  logic [2:0]  int_ni = 3'b111;
  logic        instr_end_i = 1'b0;
  logic        mcycle_end_i = 1'b0;
  logic        ei_i = 1'b0;
  logic        di_i = 1'b0;
  logic [2:0]  src_o;
  logic        ack_stb_o, bus_ack_o, float_o, ack_m1_o, ack_iorq_o, ie_o;
  logic [15:0] restart_addr_o;

  int total = 0;
  int bad = 0;

  // reference model state
  logic m_nmi_q = 1'b1, m_pend = 1'b0, m_ie = 1'b0, m_grant = 1'b0;
  logic m_stb = 1'b0, m_m1 = 1'b0;
  logic [2:0]  m_src = 3'd0;
  logic [15:0] m_addr = 16'h0;

  irq_bus_arbiter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_ni(bus_req_ni), .nmi_ni(nmi_ni),
    .int_ni(int_ni), .instr_end_i(instr_end_i), .mcycle_end_i(mcycle_end_i),
    .ei_i(ei_i), .di_i(di_i), .src_o(src_o), .ack_stb_o(ack_stb_o),
    .bus_ack_o(bus_ack_o), .float_o(float_o), .ack_m1_o(ack_m1_o),
    .ack_iorq_o(ack_iorq_o), .restart_addr_o(restart_addr_o), .ie_o(ie_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // priority pick, per R6/R8/R9/R10
  function automatic logic [2:0] pick(input logic win, input logic pend,
                                      input logic ie, input logic [2:0] ints);
    if (!win) return 3'd0;
    if (pend) return 3'd2;
    if (!ie) return 3'd0;
    if (!ints[0]) return 3'd3;
    if (!ints[1]) return 3'd4;
    if (!ints[2]) return 3'd5;
    return 3'd0;
  endfunction

  task automatic model_step();
    logic fall, btake, win, gnext;
    logic [2:0] c;
    fall  = m_nmi_q & ~nmi_ni;
    btake = ~m_grant & mcycle_end_i & ~bus_req_ni;
    win   = instr_end_i & ~m_grant & bus_req_ni;
    c     = pick(win, m_pend, m_ie, int_ni);
    gnext = m_grant ? ~bus_req_ni : btake;
    m_stb  = (c != 3'd0);
    m_src  = gnext ? 3'd1 : c;
    m_m1   = (c == 3'd3);
    m_addr = (c == 3'd2) ? 16'h0066 : 16'h0;
    m_pend = fall | (m_pend & ~(c == 3'd2));
    if (c == 3'd2) m_ie = 1'b0;
    else if (ei_i) m_ie = 1'b1;
    else if (di_i) m_ie = 1'b0;
    m_grant = gnext;
    m_nmi_q = nmi_ni;
  endtask

  task automatic compare(input string tag);
    chk(tag, "src_o", src_o, m_src);
    chk(tag, "ack_stb_o", ack_stb_o, m_stb);
    chk(tag, "bus_ack_o", bus_ack_o, m_grant);
    chk(tag, "float_o", float_o, m_grant);
    chk(tag, "ack_m1_o", ack_m1_o, m_m1);
    chk(tag, "ack_iorq_o", ack_iorq_o, m_m1);
    chk(tag, "restart_addr_o", restart_addr_o, m_addr);
    chk(tag, "ie_o", ie_o, m_ie);
  endtask

  // called at a negedge: drive, model, advance to next negedge, compare
  task automatic step(input string tag, input logic breq_n, input logic nmi_n,
                      input logic [2:0] ints, input logic ie_end, input logic mc_end,
                      input logic ei, input logic di);
    bus_req_ni = breq_n; nmi_ni = nmi_n; int_ni = ints;
    instr_end_i = ie_end; mcycle_end_i = mc_end; ei_i = ei; di_i = di;
    model_step();
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;

    // R9: enable set, then maskable masked while clear
    step("R9", 1, 1, 3'b110, 1, 1, 0, 0);
    step("R9", 1, 1, 3'b111, 0, 0, 1, 0);
    step("R10", 1, 1, 3'b110, 0, 1, 0, 0);
    // R7: INT0 taken with M1 and IORQ
    step("R7", 1, 1, 3'b110, 1, 1, 0, 0);
    // R6: INT0 beats INT1/INT2
    step("R6", 1, 1, 3'b000, 1, 1, 0, 0);
    // R8: INT1 over INT2
    step("R8", 1, 1, 3'b001, 1, 1, 0, 0);
    step("R8", 1, 1, 3'b011, 1, 1, 0, 0);
    // R2: request without mcycle end not granted
    step("R2", 0, 1, 3'b111, 0, 0, 0, 0);
    step("R2", 0, 1, 3'b111, 0, 1, 0, 0);
    // R3: grant held, interrupts blocked, then released
    step("R3", 0, 0, 3'b000, 1, 1, 0, 0);
    step("R3", 0, 0, 3'b000, 1, 1, 0, 0);
    step("R3", 1, 0, 3'b111, 0, 0, 0, 0);
    // R4: level held low gives one take, regardless of ie
    step("R4", 1, 0, 3'b111, 0, 0, 0, 1);
    step("R5", 1, 0, 3'b111, 1, 1, 1, 0);
    step("R4", 1, 0, 3'b111, 1, 1, 0, 0);
    // R10: bus request blocks interrupt at instruction end
    step("R10", 1, 1, 3'b111, 0, 0, 0, 0);
    step("R10", 1, 0, 3'b111, 0, 0, 1, 0);
    step("R10", 0, 1, 3'b110, 1, 0, 0, 0);
    step("R6", 1, 1, 3'b110, 1, 1, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R6", (r[3:0] != 0), (r[6:4] != 0), r[9:7] | {3{r[10]}},
           r[11], r[11] | r[12], (r[15:13] == 0), (r[18:16] == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule